// File: doc/BRIEF.md
# In-Order Pipeline Property Monitor

This block watches the control side of an in-order pipeline. Every cycle it reads the condition signals that the pipeline controller produces. Each instruction latch has three of them: advance, hold and bubble. The program counter also has three: step, branch and hold. The block judges these signals against a set of consistency rules. The rules cover whether each state update is unambiguous, whether neighbouring latches move in agreement, and whether a join point ever takes two instructions at once.

The latch topology is given as a static parent matrix. A latch with no parent is a first-stage latch, fed directly by the program counter. For each fork/join pair, the block stamps every instruction tag at the fork with a wrapping issue counter. When the tag reaches the join, its stamp is compared with the stamp of the previous arrival, which catches an instruction that overtakes an older one.

Each rule has its own sticky error flag, which holds until `clr` is pulsed. The block also captures the index of the first offending latch. It is meant to sit beside a controller in simulation or in silicon debug, with no effect on the pipeline itself.

Top module: `pipe_order_monitor`

## Requirements
- R1: A latch whose advance/hold/bubble inputs are not exactly one-hot in a cycle sets `err_flags[0]` after that clock edge.
- R2: Program-counter inputs step/branch/hold that are not exactly one-hot set `err_flags[1]` after the edge.
- R3: A latch that advances while it has parents and every parent holds sets `err_flags[2]`.
- R4: A latch that advances or bubbles while it has children and every child holds sets `err_flags[3]`.
- R5: A latch that bubbles while any of its parents advances or bubbles sets `err_flags[4]`.
- R6: A latch with two or more of its parents advancing in the same cycle sets `err_flags[5]`.
- R7: `err_flags[6]` is set by any of these on the program counter:
  - it holds while a first-stage latch (one with no parents) advances;
  - it steps or branches while every first-stage latch holds;
  - it steps or branches while any first-stage latch bubbles.
- R8: Each fork/join pair stamps an issued tag with a TS_W-bit wrapping counter. An arrival whose stamp minus the previous arrival's stamp (mod 2^TS_W) is zero or has its top bit set sets `err_flags[7]`. The first arrival after reset is never flagged.
- R9: Flags are sticky. A cycle with `clr` high clears them, but a violation in that same cycle still sets its flag, because set wins over clear.
- R10: When `first_vld` is low, or `clr` is high, the cycle's violations are captured into `first_idx` and `first_vld`. `first_idx` is the lowest violating latch index for rules R1 and R3 to R6, or NUM_LATCH if only the program-counter rules R2 or R7 fail. Once captured, the index holds until `clr`, and R8 does not capture.
- R11: After a synchronous active-low reset, all flags are 0, `first_vld` is 0 and the ordering history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears flags and re-arms capture |
| parent_map | input | NUM_LATCH*NUM_LATCH | Bit i*NUM_LATCH+p set: latch p is a parent of latch i |
| lat_nf | input | NUM_LATCH | Per-latch advance (normal flow) |
| lat_st | input | NUM_LATCH | Per-latch hold (stall) |
| lat_ni | input | NUM_LATCH | Per-latch bubble (nop insertion) |
| pc_seq | input | 1 | Program counter steps |
| pc_br | input | 1 | Program counter takes a branch |
| pc_st | input | 1 | Program counter holds |
| iss_vld | input | NUM_PAIR | Fork issues a tag |
| iss_tag | input | NUM_PAIR*TAG_W | Tag issued at each fork |
| arr_vld | input | NUM_PAIR | Tag arrives at join |
| arr_tag | input | NUM_PAIR*TAG_W | Tag arriving at each join |
| err_flags | output | 8 | Sticky per-rule error flags |
| first_vld | output | 1 | First offender captured |
| first_idx | output | $clog2(NUM_LATCH+1) | First offending latch, NUM_LATCH for the program counter |

## Verification
Two functions can coincide in one cycle: the clear pulse and the capture of a new violation. The sticky flags and the first-offender register must then both take the new violation rather than be wiped. The bench provokes this both by directed steps and by random cycles in which `clr` is high while random condition vectors break rules. It judges every cycle against a bench model that folds the current violations over the cleared state. A second coincidence is a fork issue and a join arrival on the same pair in the same cycle, which random traffic produces regularly.

// File: rtl/pom_pkg.sv
// Package: shared rule-bit positions for the pipeline property monitor.
// Assumes: the error vector is fixed at eight rule bits.
package pom_pkg;
    localparam int RULE_W   = 8;
    localparam int B_DET    = 0;
    localparam int B_PC_DET = 1;
    localparam int B_DUP    = 2;
    localparam int B_LOSS   = 3;
    localparam int B_NOP    = 4;
    localparam int B_JOIN   = 5;
    localparam int B_PC_ORD = 6;
    localparam int B_ORDER  = 7;
endpackage

// File: rtl/pom_latch_rules.sv
// Module: per-latch combinational rule evaluation (R1, R3..R6).
// Assumes: parent_map is static; row i lists the parents of latch i.
module pom_latch_rules #(
    parameter int NUM_LATCH = 6
) (
    input  logic [NUM_LATCH*NUM_LATCH-1:0] parent_map,
    input  logic [NUM_LATCH-1:0]           lat_nf,
    input  logic [NUM_LATCH-1:0]           lat_st,
    input  logic [NUM_LATCH-1:0]           lat_ni,
    output logic [NUM_LATCH-1:0]           det_bad,
    output logic [NUM_LATCH-1:0]           dup_bad,
    output logic [NUM_LATCH-1:0]           loss_bad,
    output logic [NUM_LATCH-1:0]           nop_bad,
    output logic [NUM_LATCH-1:0]           join_bad,
    output logic [NUM_LATCH-1:0]           first_stage
);
    localparam logic [NUM_LATCH-1:0] ONE = NUM_LATCH'(1);

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_lat
        logic [NUM_LATCH-1:0] par;
        logic [NUM_LATCH-1:0] kid;
        logic [NUM_LATCH-1:0] par_nf;

        assign par    = parent_map[i*NUM_LATCH +: NUM_LATCH];
        assign par_nf = par & lat_nf;

        // Gather the children of latch i from the other rows.
        always_comb begin
            for (int j = 0; j < NUM_LATCH; j++) begin
                kid[j] = parent_map[j*NUM_LATCH + i];
            end
        end

        assign det_bad[i]     = (lat_nf[i] & lat_st[i]) | (lat_nf[i] & lat_ni[i])
                              | (lat_st[i] & lat_ni[i]) | ~(lat_nf[i] | lat_st[i] | lat_ni[i]);
        assign dup_bad[i]     = lat_nf[i] & (|par) & ~(|(par & ~lat_st));
        assign loss_bad[i]    = (lat_nf[i] | lat_ni[i]) & (|kid) & ~(|(kid & ~lat_st));
        assign nop_bad[i]     = lat_ni[i] & (|(par & (lat_nf | lat_ni)));
        assign join_bad[i]    = |(par_nf & (par_nf - ONE));
        assign first_stage[i] = ~(|par);
    end
endmodule

// File: rtl/pom_pc_rules.sv
// Module: program-counter rule evaluation (R2, R7).
// Assumes: first_stage marks latches fed directly by the program counter.
module pom_pc_rules #(
    parameter int NUM_LATCH = 6
) (
    input  logic                 pc_seq,
    input  logic                 pc_br,
    input  logic                 pc_st,
    input  logic [NUM_LATCH-1:0] first_stage,
    input  logic [NUM_LATCH-1:0] lat_nf,
    input  logic [NUM_LATCH-1:0] lat_st,
    input  logic [NUM_LATCH-1:0] lat_ni,
    output logic                 pc_det_bad,
    output logic                 pc_ord_bad
);
    logic moves;
    logic fs_all_st;

    assign moves      = pc_seq | pc_br;
    assign fs_all_st  = (|first_stage) & ~(|(first_stage & ~lat_st));
    assign pc_det_bad = (pc_seq & pc_br) | (pc_seq & pc_st) | (pc_br & pc_st)
                      | ~(pc_seq | pc_br | pc_st);
    assign pc_ord_bad = (pc_st & (|(first_stage & lat_nf)))
                      | (moves & fs_all_st)
                      | (moves & (|(first_stage & lat_ni)));
endmodule

// File: rtl/pom_order_track.sv
// Module: fork/join issue-stamp tracker for one pair (R8).
// Assumes: in-flight tags are unique and fewer than 2**(TS_W-1);
//          an arriving tag was issued in an earlier cycle.
module pom_order_track #(
    parameter int TAG_W = 3,
    parameter int TS_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_vld,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             arr_vld,
    input  logic [TAG_W-1:0] arr_tag,
    output logic             order_bad
);
    localparam int DEPTH = 2**TAG_W;

    logic [TS_W-1:0] stamp_tab [DEPTH];
    logic [TS_W-1:0] ts_cnt;
    logic [TS_W-1:0] last_ts;
    logic            seen;
    logic [TS_W-1:0] arr_ts;
    logic [TS_W-1:0] diff;

    assign arr_ts    = stamp_tab[arr_tag];
    assign diff      = arr_ts - last_ts;
    assign order_bad = arr_vld & seen & ((diff == '0) | diff[TS_W-1]);

    // Record the issue stamp of each tag leaving the fork.
    always_ff @(posedge clk) begin
        if (iss_vld) begin
            stamp_tab[iss_tag] <= ts_cnt;
        end
    end

    // Advance the issue counter and remember the last join arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_cnt  <= '0;
            last_ts <= '0;
            seen    <= 1'b0;
        end else begin
            if (iss_vld) begin
                ts_cnt <= ts_cnt + TS_W'(1);
            end
            if (arr_vld) begin
                last_ts <= arr_ts;
                seen    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pom_err_capture.sv
// Module: sticky flags and first-offender capture (R9, R10, R11).
// Assumes: set has priority over clear in the same cycle.
module pom_err_capture
    import pom_pkg::*;
#(
    parameter int NUM_LATCH = 6,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [RULE_W-1:0]    err_now,
    input  logic [NUM_LATCH-1:0] lat_viol,
    output logic [RULE_W-1:0]    err_flags,
    output logic                 first_vld,
    output logic [IDX_W-1:0]     first_idx
);
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] cap_idx;
    logic             hit;

    // Lowest-numbered violating latch.
    always_comb begin
        lo_idx = '0;
        for (int k = NUM_LATCH - 1; k >= 0; k--) begin
            if (lat_viol[k]) lo_idx = IDX_W'(k);
        end
    end

    assign hit     = (|lat_viol) | err_now[B_PC_DET] | err_now[B_PC_ORD];
    assign cap_idx = (|lat_viol) ? lo_idx : IDX_W'(NUM_LATCH);

    // Accumulate flags and capture the first offender once per clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flags <= '0;
            first_vld <= 1'b0;
            first_idx <= '0;
        end else begin
            err_flags <= (clr ? '0 : err_flags) | err_now;
            if (clr || !first_vld) begin
                first_vld <= hit;
                first_idx <= hit ? cap_idx : '0;
            end
        end
    end
endmodule

// File: rtl/pipe_order_monitor.sv
// Module: top of the in-order pipeline property monitor.
// Assumes: condition inputs are sampled at each rising edge; parent_map static.
module pipe_order_monitor
    import pom_pkg::*;
#(
    parameter int NUM_LATCH = 6,
    parameter int NUM_PAIR  = 1,
    parameter int TAG_W     = 3,
    parameter int TS_W      = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic [NUM_LATCH*NUM_LATCH-1:0]  parent_map,
    input  logic [NUM_LATCH-1:0]            lat_nf,
    input  logic [NUM_LATCH-1:0]            lat_st,
    input  logic [NUM_LATCH-1:0]            lat_ni,
    input  logic                            pc_seq,
    input  logic                            pc_br,
    input  logic                            pc_st,
    input  logic [NUM_PAIR-1:0]             iss_vld,
    input  logic [NUM_PAIR*TAG_W-1:0]       iss_tag,
    input  logic [NUM_PAIR-1:0]             arr_vld,
    input  logic [NUM_PAIR*TAG_W-1:0]       arr_tag,
    output logic [RULE_W-1:0]               err_flags,
    output logic                            first_vld,
    output logic [$clog2(NUM_LATCH+1)-1:0]  first_idx
);
    localparam int IDX_W = $clog2(NUM_LATCH + 1);

    logic [NUM_LATCH-1:0] det_bad, dup_bad, loss_bad, nop_bad, join_bad;
    logic [NUM_LATCH-1:0] first_stage;
    logic [NUM_LATCH-1:0] lat_viol;
    logic                 pc_det_bad, pc_ord_bad;
    logic [NUM_PAIR-1:0]  order_bad;
    logic [RULE_W-1:0]    err_now;

    pom_latch_rules #(.NUM_LATCH(NUM_LATCH)) u_lat (
        .parent_map (parent_map),
        .lat_nf     (lat_nf),
        .lat_st     (lat_st),
        .lat_ni     (lat_ni),
        .det_bad    (det_bad),
        .dup_bad    (dup_bad),
        .loss_bad   (loss_bad),
        .nop_bad    (nop_bad),
        .join_bad   (join_bad),
        .first_stage(first_stage)
    );

    pom_pc_rules #(.NUM_LATCH(NUM_LATCH)) u_pc (
        .pc_seq     (pc_seq),
        .pc_br      (pc_br),
        .pc_st      (pc_st),
        .first_stage(first_stage),
        .lat_nf     (lat_nf),
        .lat_st     (lat_st),
        .lat_ni     (lat_ni),
        .pc_det_bad (pc_det_bad),
        .pc_ord_bad (pc_ord_bad)
    );

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        pom_order_track #(.TAG_W(TAG_W), .TS_W(TS_W)) u_ord (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_vld  (iss_vld[p]),
            .iss_tag  (iss_tag[p*TAG_W +: TAG_W]),
            .arr_vld  (arr_vld[p]),
            .arr_tag  (arr_tag[p*TAG_W +: TAG_W]),
            .order_bad(order_bad[p])
        );
    end

    assign lat_viol = det_bad | dup_bad | loss_bad | nop_bad | join_bad;

    // Assemble this cycle's rule violations.
    always_comb begin
        err_now           = '0;
        err_now[B_DET]    = |det_bad;
        err_now[B_PC_DET] = pc_det_bad;
        err_now[B_DUP]    = |dup_bad;
        err_now[B_LOSS]   = |loss_bad;
        err_now[B_NOP]    = |nop_bad;
        err_now[B_JOIN]   = |join_bad;
        err_now[B_PC_ORD] = pc_ord_bad;
        err_now[B_ORDER]  = |order_bad;
    end

    pom_err_capture #(.NUM_LATCH(NUM_LATCH), .IDX_W(IDX_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .err_now  (err_now),
        .lat_viol (lat_viol),
        .err_flags(err_flags),
        .first_vld(first_vld),
        .first_idx(first_idx)
    );
endmodule

// File: rtl/pom_sva.sv
// Module: assertion checker bound to pipe_order_monitor.
// Assumes: reset is held for at least one clock before checks matter.
module pom_sva
    import pom_pkg::*;
#(
    parameter int NUM_LATCH = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           clr,
    input logic [NUM_LATCH-1:0]           lat_nf,
    input logic [NUM_LATCH-1:0]           lat_st,
    input logic [NUM_LATCH-1:0]           lat_ni,
    input logic                           pc_seq,
    input logic                           pc_br,
    input logic                           pc_st,
    input logic [RULE_W-1:0]              err_flags,
    input logic                           first_vld,
    input logic [$clog2(NUM_LATCH+1)-1:0] first_idx
);
    AST_DET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (((lat_nf & lat_st) | (lat_nf & lat_ni) | (lat_st & lat_ni) | ~(lat_nf | lat_st | lat_ni)) != '0)
        |=> err_flags[B_DET]); // R1
    AST_PC_DET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot({pc_seq, pc_br, pc_st}) |=> err_flags[B_PC_DET]); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R9
    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld && !clr) |=> (first_vld && $stable(first_idx))); // R10
    AST_FIRST_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        first_vld |-> (err_flags[B_JOIN:B_DET] != '0 || err_flags[B_PC_ORD])); // R10
    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (err_flags == '0 && !first_vld)); // R11
endmodule

bind pipe_order_monitor pom_sva #(.NUM_LATCH(NUM_LATCH)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .lat_nf   (lat_nf),
    .lat_st   (lat_st),
    .lat_ni   (lat_ni),
    .pc_seq   (pc_seq),
    .pc_br    (pc_br),
    .pc_st    (pc_st),
    .err_flags(err_flags),
    .first_vld(first_vld),
    .first_idx(first_idx)
);

// File: tb/pipe_order_monitor_bench.sv
`timescale 1ns/1ps
// Bench: random plus directed stimulus against a bench-side rule model.
module pipe_order_monitor_bench;
    localparam int N  = 6;
    localparam int P  = 2;
    localparam int TW = 3;
    localparam int SW = 5;

    // Topology: L0 first stage, L1<-L0, L2<-L1, L3<-L1 (fork), L4<-L2,L3 (join), L5<-L4
    localparam logic [N-1:0] PAR [N] = '{6'b000000, 6'b000001, 6'b000010,
                                         6'b000010, 6'b001100, 6'b010000};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic [N*N-1:0]  parent_map;
    logic [N-1:0]    lat_nf = '0, lat_st = '0, lat_ni = '0;
    logic            pc_seq = 1'b0, pc_br = 1'b0, pc_st = 1'b0;
    logic [P-1:0]    iss_vld = '0, arr_vld = '0;
    logic [P*TW-1:0] iss_tag = '0, arr_tag = '0;
    logic [7:0]      err_flags;
    logic            first_vld;
    logic [2:0]      first_idx;

    always #4 clk = ~clk;

    pipe_order_monitor #(.NUM_LATCH(N), .NUM_PAIR(P), .TAG_W(TW), .TS_W(SW)) u_pipe_order_monitor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .parent_map(parent_map),
        .lat_nf(lat_nf), .lat_st(lat_st), .lat_ni(lat_ni),
        .pc_seq(pc_seq), .pc_br(pc_br), .pc_st(pc_st),
        .iss_vld(iss_vld), .iss_tag(iss_tag), .arr_vld(arr_vld), .arr_tag(arr_tag),
        .err_flags(err_flags), .first_vld(first_vld), .first_idx(first_idx)
    );

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [7:0] exp_flags = '0;
    bit   exp_fv = 0;
    int   exp_fi = 0;
    int   stamp [P][8];
    int   tcnt [P], last_ts [P];
    bit   seen [P];
    bit   busy [P][8];

    localparam logic [N-1:0] BASE_NF = 6'b110111;
    localparam logic [N-1:0] BASE_ST = 6'b001000;

    // Expected per-cycle violations from the requirements; lo = first latch or N.
    function automatic logic [7:0] rule_model(input logic [N-1:0] nf, st, ni,
                                              input logic ps, pb, pst, output int lo);
        logic [7:0] f = '0;
        logic [N-1:0] kid;
        bit fs_any_nf = 0, fs_any_ni = 0, fs_all_st = 1, fs_exist = 0;
        lo = -1;
        for (int i = 0; i < N; i++) begin
            bit v = 0;
            int cnt = 0, pn = 0;
            for (int j = 0; j < N; j++) kid[j] = PAR[j][i];
            if ((int'(nf[i]) + int'(st[i]) + int'(ni[i])) != 1) begin f[0] = 1; v = 1; end   // R1
            if (nf[i] && PAR[i] != 0 && (PAR[i] & ~st) == 0) begin f[2] = 1; v = 1; end      // R3
            if ((nf[i] || ni[i]) && kid != 0 && (kid & ~st) == 0) begin f[3] = 1; v = 1; end  // R4
            if (ni[i] && (PAR[i] & (nf | ni)) != 0) begin f[4] = 1; v = 1; end                // R5
            for (int j = 0; j < N; j++) if (PAR[i][j] && nf[j]) pn++;
            if (pn >= 2) begin f[5] = 1; v = 1; end                                           // R6
            if (v && lo < 0) lo = i;
            if (PAR[i] == 0) begin
                fs_exist = 1;
                if (nf[i]) fs_any_nf = 1;
                if (ni[i]) fs_any_ni = 1;
                if (!st[i]) fs_all_st = 0;
            end
            cnt = cnt;
        end
        if ((int'(ps) + int'(pb) + int'(pst)) != 1) f[1] = 1;                                 // R2
        if ((pst && fs_any_nf) || ((ps || pb) && fs_exist && fs_all_st) || ((ps || pb) && fs_any_ni))
            f[6] = 1;                                                                         // R7
        if (lo < 0 && (f[1] || f[6])) lo = N;
        return f;
    endfunction

    task automatic chk(input string rq, input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic reset_model();
        exp_flags = '0; exp_fv = 0; exp_fi = 0;
        for (int p = 0; p < P; p++) begin
            tcnt[p] = 0; last_ts[p] = 0; seen[p] = 0;
            for (int t = 0; t < 8; t++) busy[p][t] = 0;
        end
    endtask

    // Drive one cycle, predict outputs, sample after the edge.
    task automatic step(input string rq, input logic [N-1:0] nf, st, ni,
                        input logic ps, pb, pst, input logic c,
                        input logic [P-1:0] iv, input logic [P*TW-1:0] it,
                        input logic [P-1:0] av, input logic [P*TW-1:0] at);
        logic [7:0] now;
        int lo;
        lat_nf = nf; lat_st = st; lat_ni = ni;
        pc_seq = ps; pc_br = pb; pc_st = pst; clr = c;
        iss_vld = iv; iss_tag = it; arr_vld = av; arr_tag = at;
        now = rule_model(nf, st, ni, ps, pb, pst, lo);
        for (int p = 0; p < P; p++) begin
            if (av[p]) begin   // R8 arrival judged on the stamp difference
                int tg = int'(at[p*TW +: TW]);
                int d = (stamp[p][tg] - last_ts[p]) & 31;
                if (seen[p] && (d == 0 || d >= 16)) now[7] = 1;
                last_ts[p] = stamp[p][tg]; seen[p] = 1; busy[p][tg] = 0;
            end
            if (iv[p]) begin
                int tg = int'(it[p*TW +: TW]);
                stamp[p][tg] = tcnt[p]; tcnt[p] = (tcnt[p] + 1) & 31; busy[p][tg] = 1;
            end
        end
        exp_flags = (c ? 8'h00 : exp_flags) | now;
        if (c || !exp_fv) begin
            exp_fv = (lo >= 0);
            exp_fi = (lo >= 0) ? lo : 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rq, err_flags == exp_flags, "err_flags", int'(err_flags), int'(exp_flags));
        chk(rq, first_vld == exp_fv, "first_vld", int'(first_vld), int'(exp_fv));
        if (exp_fv) chk(rq, int'(first_idx) == exp_fi, "first_idx", int'(first_idx), exp_fi);
    endtask

    task automatic base(input string rq, input logic c);
        step(rq, BASE_NF, BASE_ST, '0, 1, 0, 0, c, '0, '0, '0, '0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) parent_map[i*N +: N] = PAR[i];
        void'($urandom(32'd20240607));
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11", err_flags == 8'h00, "reset flags", int'(err_flags), 0);
        chk("R11", first_vld == 1'b0, "reset first_vld", int'(first_vld), 0);

        base("R9 legal baseline", 1);
        step("R1 latch none asserted", BASE_NF & ~6'b100000, BASE_ST, '0, 1, 0, 0, 1, '0, '0, '0, '0);
        step("R2 pc two asserted", BASE_NF, BASE_ST, '0, 1, 1, 0, 1, '0, '0, '0, '0);
        step("R3 advance under held parent", 6'b111110, 6'b001001, '0, 0, 0, 1, 1, '0, '0, '0, '0);
        step("R4 advance into held child", 6'b010111, 6'b101000, '0, 1, 0, 0, 1, '0, '0, '0, '0);
        step("R5 bubble behind advancing parent", 6'b100111, 6'b001000, 6'b010000, 1, 0, 0, 1, '0, '0, '0, '0);
        step("R6 two parents advance into join", 6'b111111, '0, '0, 1, 0, 0, 1, '0, '0, '0, '0);
        step("R7 pc steps over bubbling first latch", 6'b110110, 6'b001000, 6'b000001, 1, 0, 0, 1, '0, '0, '0, '0);
        step("R7 pc holds while first latch advances", BASE_NF, BASE_ST, '0, 0, 0, 1, 1, '0, '0, '0, '0);
        // R10: first offender held across a later, lower-index violation
        step("R10 capture L4", 6'b010111, 6'b101000, '0, 1, 0, 0, 1, '0, '0, '0, '0);
        step("R10 hold against L1", 6'b111110, 6'b001001, '0, 0, 0, 1, 0, '0, '0, '0, '0);
        base("R9 sticky without clear", 0);
        base("R9 clear with no violation", 1);
        // R9: clear and a new violation in the same cycle
        step("R9 set wins over clear", BASE_NF & ~6'b100000, BASE_ST, '0, 1, 0, 0, 1, '0, '0, '0, '0);
        // R8: issue tags 1,2 then arrive out of order on pair 0
        step("R8 issue tag1", BASE_NF, BASE_ST, '0, 1, 0, 0, 1, 2'b01, 6'o01, '0, '0);
        step("R8 issue tag2", BASE_NF, BASE_ST, '0, 1, 0, 0, 1, 2'b01, 6'o02, '0, '0);
        step("R8 first arrival not flagged", BASE_NF, BASE_ST, '0, 1, 0, 0, 1, '0, '0, 2'b01, 6'o02);
        step("R8 older tag arrives late", BASE_NF, BASE_ST, '0, 1, 0, 0, 1, '0, '0, 2'b01, 6'o01);
        chk("R8", err_flags[7] == 1'b1, "order flag", int'(err_flags[7]), 1);

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [N-1:0] nf = '0, st = '0, ni = '0;
            logic ps = 0, pb = 0, pst = 0, c;
            logic [P-1:0] iv = '0, av = '0;
            logic [P*TW-1:0] it = '0, at = '0;
            bit legalish = ($urandom % 2) == 0;
            for (int i = 0; i < N; i++) begin
                int r = int'($urandom % 16);
                if (legalish) begin nf[i] = BASE_NF[i]; st[i] = BASE_ST[i]; end
                else if (r < 6) nf[i] = 1;
                else if (r < 11) st[i] = 1;
                else if (r < 14) ni[i] = 1;
                else if (r == 15) begin nf[i] = 1; st[i] = 1; end
            end
            begin
                int r = int'($urandom % 8);
                if (legalish || r < 4) ps = 1; else if (r < 6) pst = 1; else if (r < 7) pb = 1;
                else begin ps = 1; pb = 1; end
            end
            c = ($urandom % 4) == 0;
            for (int p = 0; p < P; p++) begin
                int cnt_busy = 0, pick = -1, best_age = -1;
                for (int t = 0; t < 8; t++) if (busy[p][t]) begin
                    int age = (tcnt[p] - stamp[p][t]) & 31;
                    cnt_busy++;
                    if (age > best_age) begin best_age = age; pick = t; end
                end
                if (cnt_busy > 0 && ($urandom % 2) == 0) begin
                    if (($urandom % 4) == 0) begin
                        int k = int'($urandom % 8);
                        for (int t = 0; t < 8; t++) if (busy[p][(k + t) % 8]) begin pick = (k + t) % 8; break; end
                    end
                    av[p] = 1; at[p*TW +: TW] = TW'(pick);
                end
                if (cnt_busy < 7 && ($urandom % 2) == 0) begin
                    for (int t = 0; t < 8; t++) if (!busy[p][t] && !(av[p] && pick == t)) begin
                        iv[p] = 1; it[p*TW +: TW] = TW'(t); break;
                    end
                end
            end
            step("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random", nf, st, ni, ps, pb, pst, c, iv, it, av, at);
        end

        // R11: reset in mid-run clears flags and ordering history
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        reset_model();
        chk("R11", err_flags == 8'h00 && !first_vld, "flags after reset", int'(err_flags), 0);
        step("R11 issue after reset", BASE_NF, BASE_ST, '0, 1, 0, 0, 0, 2'b10, 6'o50, '0, '0);
        step("R11 first arrival after reset", BASE_NF, BASE_ST, '0, 1, 0, 0, 0, '0, '0, 2'b10, 6'o50);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule